// File: doc/BRIEF.md
# Per-Strand Pause Counter

This block holds a hardware thread stalled for a software-chosen number of clock cycles. Each thread, or strand, has its own pause register. A write to that register starts a countdown at a coarse granularity of 2^GRAN_LOG2 cycles, which is 8 by default. The value loaded is the written cycle count shifted right by GRAN_LOG2. While the countdown runs, the strand's blocked output stays high. A scheduler outside this block can use that output to hand the core to other strands.

A pause ends in one of two ways. Either the countdown expires, or a disrupting trap arrives for that strand and cuts the pause short. In both cases a one-cycle done pulse follows. A write whose value is below the granule still stalls the strand for a single cycle. A new write during a pause replaces what is left of the old one.

Each strand runs the state machine `pause_strand_fsm`, which has three states:
- IDLE: not blocked.
- SINGLE: a one-cycle stall for small values.
- COUNTING: the coarse countdown.

Transitions:
- IDLE→SINGLE and IDLE→COUNTING on a write, chosen by whether the shifted value is zero.
- SINGLE→IDLE always on the next edge (expire).
- COUNTING→IDLE on a tick with one granule left (expire) or on a trap (abort).
- COUNTING→COUNTING on a tick with more granules left (decrement) or on a write (reload).
- SINGLE→SINGLE and SINGLE→COUNTING on a write (reload).
- Any non-idle state→IDLE on a trap without a write (abort).

The tick comes from a GRAN_LOG2-bit prescaler that restarts at zero on every write.

Top module: `pause_counter_top`

## Requirements
- R1: After reset, every blocked output and every done output is low.
- R2: A write accepted at a clock edge makes that strand's blocked output high from the next cycle onward.
- R3: For a written value v with v >= 8 (default granule), blocked stays high for exactly 8*(v>>3) consecutive cycles. The countdown decrements once per 8 cycles, with the prescaler restarted by the write.
- R4: For a written value v < 8, blocked stays high for exactly 1 cycle.
- R5: A trap asserted for a strand in a cycle where it is blocked and not being written makes blocked low in the next cycle.
- R6: Done is high for exactly one cycle: the first cycle in which blocked is low after a pause ends, whether by expiry or by trap.
- R7: A write while a pause is active replaces the remaining count and restarts the prescaler. The duration then follows R3/R4 counted from the new write, and no done pulse is issued for the replaced pause.
- R8: When write and trap are asserted for a strand in the same cycle, the write takes effect and the trap is ignored.
- R9: A trap to an idle strand has no effect: blocked and done stay low.
- R10: Strands are independent. A write or trap to one strand does not change another strand's blocked or done outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | N_STRANDS | Per-strand write strobe to the pause register |
| wr_value | input | N_STRANDS*VAL_W | Per-strand requested cycle count; strand i occupies bits [i*VAL_W +: VAL_W] |
| trap | input | N_STRANDS | Per-strand disrupting-trap indication |
| blocked | output | N_STRANDS | Strand is stalled |
| done | output | N_STRANDS | One-cycle pulse after a pause ends |

## Verification
A wrong count value or a prescaler that does not restart shows up at the ports as a blocked interval that is longer or shorter than expected. The error is visible at the falling edge of blocked, so at the latest 8*(v>>3) cycles after the write. A state machine stuck outside IDLE shows as blocked never falling, or as a missing or duplicated done pulse one cycle after the fall. The bench sweeps every written value of an 8-bit configuration and measures the exact interval. Mis-ordered priority between write and trap shows in the very next cycle.

// File: rtl/pause_pkg.sv
package pause_pkg;

    typedef enum logic [1:0] {
        PS_IDLE     = 2'd0,
        PS_SINGLE   = 2'd1,
        PS_COUNTING = 2'd2
    } pause_state_e;

endpackage

// File: rtl/pause_prescaler.sv
module pause_prescaler #(
    parameter int GRAN_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);

    localparam logic [GRAN_LOG2-1:0] LAST = '1;

    logic [GRAN_LOG2-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = run && !restart && (phase_q == LAST);

    // R3: restart always returns the phase to zero
    a_r3_prescaler_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == '0));

endmodule

// File: rtl/pause_strand_fsm.sv
module pause_strand_fsm
    import pause_pkg::*;
#(
    parameter int VAL_W     = 16,
    parameter int GRAN_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VAL_W-1:0] wr_value,
    input  logic             trap,
    output logic             blocked,
    output logic             done
);

    localparam int CNT_W = VAL_W - GRAN_LOG2;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    pause_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_d;
    logic             done_q;
    logic             tick;
    logic [CNT_W-1:0] load_val;

    assign load_val = wr_value[VAL_W-1:GRAN_LOG2];

    pause_prescaler #(
        .GRAN_LOG2(GRAN_LOG2)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(wr_en),
        .run    (state_q == PS_COUNTING),
        .tick   (tick)
    );

    // next-state and count logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        if (wr_en) begin
            cnt_d   = load_val;
            state_d = (load_val == '0) ? PS_SINGLE : PS_COUNTING;
        end else if (trap && state_q != PS_IDLE) begin
            state_d = PS_IDLE;
            cnt_d   = '0;
            done_d  = 1'b1;
        end else begin
            unique case (state_q)
                PS_IDLE: begin
                    state_d = PS_IDLE;
                end
                PS_SINGLE: begin
                    state_d = PS_IDLE;
                    done_d  = 1'b1;
                end
                PS_COUNTING: begin
                    if (tick) begin
                        if (cnt_q == ONE) begin
                            state_d = PS_IDLE;
                            cnt_d   = '0;
                            done_d  = 1'b1;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                default: begin
                    state_d = PS_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= done_d;
        end
    end

    assign blocked = (state_q != PS_IDLE);
    assign done    = done_q;

    // R2 / R8: a write always blocks the strand next cycle
    a_r2_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> blocked);
    // R5: trap without write releases the strand next cycle
    a_r5_trap_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && !wr_en) |=> !blocked);
    // R6: done is a single-cycle pulse following a blocked cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_done_after_block: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!blocked && $past(blocked)));
    // R3: the counting state never holds a zero count
    a_r3_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_COUNTING) |-> (cnt_q != '0));
    // R4: the single-cycle state lasts one cycle unless rewritten
    a_r4_single_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_SINGLE && !wr_en) |=> (state_q == PS_IDLE));

endmodule

// File: rtl/pause_counter_top.sv
module pause_counter_top #(
    parameter int N_STRANDS = 4,
    parameter int VAL_W     = 16,
    parameter int GRAN_LOG2 = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_STRANDS-1:0]       wr_en,
    input  logic [N_STRANDS*VAL_W-1:0] wr_value,
    input  logic [N_STRANDS-1:0]       trap,
    output logic [N_STRANDS-1:0]       blocked,
    output logic [N_STRANDS-1:0]       done
);

    for (genvar s = 0; s < N_STRANDS; s++) begin : g_strand
        pause_strand_fsm #(
            .VAL_W    (VAL_W),
            .GRAN_LOG2(GRAN_LOG2)
        ) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[s]),
            .wr_value(wr_value[s*VAL_W +: VAL_W]),
            .trap    (trap[s]),
            .blocked (blocked[s]),
            .done    (done[s])
        );
    end

    // R1: nothing is blocked or signalled in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (blocked == '0 && done == '0));

endmodule

// File: tb/sim_pause_counter_top.sv
module sim_pause_counter_top;

    localparam int NS = 2;
    localparam int VW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   wr_en = '0;
    logic [NS*VW-1:0] wr_value = '0;
    logic [NS-1:0]   trap = '0;
    logic [NS-1:0]   blocked;
    logic [NS-1:0]   done;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    pause_counter_top #(.N_STRANDS(NS), .VAL_W(VW), .GRAN_LOG2(3)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_value(wr_value),
        .trap(trap), .blocked(blocked), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expected_len(input int v);
        return (v < 8) ? 1 : 8 * (v / 8);
    endfunction

    // issue one write to strand s during the next cycle
    task automatic write_strand(input int s, input int v, input bit with_trap);
        wr_en[s] = 1'b1;
        wr_value[s*VW +: VW] = VW'(v);
        trap[s] = with_trap;
        @(negedge clk);
        wr_en[s] = 1'b0;
        trap[s] = 1'b0;
    endtask

    // count the blocked cycles of strand s; done must stay low meanwhile
    task automatic measure(input int s, output int len, output int early_done);
        len = 0;
        early_done = 0;
        while (blocked[s] && len < 4000) begin
            if (done[s]) early_done++;
            len++;
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int len, ed;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 blocked", int'(blocked), 0);
        check("R1 done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 blocked after release", int'(blocked), 0);

        // R2 R3 R4 R6: sweep every value on strand 0
        for (int v = 0; v < 256; v++) begin
            write_strand(0, v, 1'b0);
            check("R2 blocked after write", int'(blocked[0]), 1);
            measure(0, len, ed);
            if (v < 8) check("R4 short length", len, expected_len(v));
            else       check("R3 length", len, expected_len(v));
            check("R6 no early done", ed, 0);
            check("R6 done pulse", int'(done[0]), 1);
            @(negedge clk);
            check("R6 done one cycle", int'(done[0]), 0);
        end

        // R5 R6: trap at varied points
        for (int k = 0; k < 40; k += 3) begin
            write_strand(1, 80, 1'b0);
            repeat (k) @(negedge clk);
            trap[1] = 1'b1;
            @(negedge clk);
            trap[1] = 1'b0;
            check("R5 trap releases", int'(blocked[1]), 0);
            check("R6 done after trap", int'(done[1]), 1);
            @(negedge clk);
            check("R6 done one cycle after trap", int'(done[1]), 0);
        end

        // R5: trap during a single-cycle pause
        write_strand(0, 3, 1'b0);
        trap[0] = 1'b1;
        @(negedge clk);
        trap[0] = 1'b0;
        check("R5 trap single", int'(blocked[0]), 0);
        check("R6 done single trap", int'(done[0]), 1);
        @(negedge clk);

        // R7: rewrite during active pause
        for (int k = 1; k < 30; k += 7) begin
            write_strand(0, 40, 1'b0);
            repeat (k) @(negedge clk);
            check("R7 no done before rewrite", int'(done[0]), 0);
            write_strand(0, 24, 1'b0);
            measure(0, len, ed);
            check("R7 length after rewrite", len, 24);
            check("R7 no done for replaced pause", ed, 0);
            check("R7 final done", int'(done[0]), 1);
            @(negedge clk);
        end
        write_strand(0, 64, 1'b0);
        repeat (5) @(negedge clk);
        write_strand(0, 2, 1'b0);
        measure(0, len, ed);
        check("R7 rewrite short length", len, 1);
        @(negedge clk);

        // R8: write and trap together while active, and while idle
        write_strand(1, 32, 1'b0);
        repeat (4) @(negedge clk);
        write_strand(1, 16, 1'b1);
        check("R8 write beats trap", int'(blocked[1]), 1);
        measure(1, len, ed);
        check("R8 length", len, 16);
        check("R8 no done on trap", ed, 0);
        @(negedge clk);
        write_strand(1, 9, 1'b1);
        measure(1, len, ed);
        check("R8 idle write with trap", len, 8);
        @(negedge clk);

        // R9: trap while idle
        trap = '1;
        @(negedge clk);
        trap = '0;
        check("R9 blocked idle trap", int'(blocked), 0);
        check("R9 done idle trap", int'(done), 0);
        @(negedge clk);
        check("R9 done stays low", int'(done), 0);

        // R10: strand independence
        write_strand(0, 64, 1'b0);
        check("R10 other strand unblocked", int'(blocked[1]), 0);
        write_strand(1, 16, 1'b0);
        repeat (3) @(negedge clk);
        trap[1] = 1'b1;
        @(negedge clk);
        trap[1] = 1'b0;
        check("R10 trap hits own strand", int'(blocked[1]), 0);
        check("R10 other strand still blocked", int'(blocked[0]), 1);
        check("R10 other strand no done", int'(done[0]), 0);
        measure(0, len, ed);
        check("R10 strand 0 length intact", len, 64 - 5);
        check("R10 strand 1 quiet", int'(blocked[1] | done[1]), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule